// File: doc/BRIEF.md
# Circular Pre-roll Stream Copier

This engine moves audio samples from a circular capture buffer, which a producer fills in source memory, into a circular playback-side buffer in destination memory. The first 32-bit location of the source region holds the producer's write pointer, and the samples follow it. On each `poll_i` the engine reads that pointer and turns it into a zero-based offset. It then works out how many bytes have arrived since its own read offset, allowing for wraparound. It copies them one sample word at a time, in steps that never cross a period boundary, and pulses `period_o` each time a full period of bytes has landed in the destination.

A `trigger_i` pulse, for example from a keyword detector, arms a rewind. The next poll that finds a valid pointer places the read offset a fixed pre-roll distance behind the write offset, so the audio leading up to the event is delivered as well. Copies are split where the source sample area wraps and where the destination buffer wraps. A copy too large for the destination keeps only its newest bytes, leaving one frame of the destination unused. Software sets the destination size and the period length through plain inputs, and clears the destination position with `prepare_i` before a stream starts.

Top module: `preroll_copier`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `period_o`, `src_req_o` and `dst_req_o` are low, and `dst_frame_o` is 0.
- R2: A poll reads the pointer from source words SRC_BASE+0 upward, lower word first, then subtracts 4. If the result is not below the sample-area size (REGION_BYTES-4), the poll ends with `error_o` and no destination write occurs.
- R3: New bytes are write minus read when read is not above write, and otherwise sample-area size plus write minus read. A poll with no new bytes finishes with no destination write.
- R4: After `trigger_i`, the first poll with a valid pointer sets the read offset to write minus PREROLL_BYTES, taken modulo the sample-area size. A poll that fails on its pointer leaves the rewind pending.
- R5: Each copy step moves the smaller of the remaining new bytes and the room left in the current period. `period_o` pulses once when the period accumulator reaches `period_bytes_i`, and the accumulator then clears. The accumulator is carried across polls.
- R6: Sample byte offset b is read from source word SRC_BASE + 4/(DATA_W/8) + b/(DATA_W/8). A range that passes the end of the sample area continues from offset 0.
- R7: A piece longer than `dst_bytes_i` minus one frame copies only its last (`dst_bytes_i` minus one frame) bytes.
- R8: Destination byte offset d is written at word DST_BASE + d/(DATA_W/8). A piece that passes the end of the destination continues at offset 0. An offset that lands exactly on the end becomes 0.
- R9: If `dst_bytes_i` is below two frames, or `period_bytes_i` is 0, while bytes remain to copy, the poll ends with `error_o`, no destination write occurs, and the read offset keeps its value.
- R10: `prepare_i` while idle clears the destination offset and the period accumulator. `dst_frame_o` is the destination offset divided by the frame size.
- R11: Each request holds its address (and, for writes, its data) until accepted. The two ports never request together, and neither requests while `busy_o` is low.
- R12: `done_o` pulses once at the end of every poll, and `error_o` only ever pulses together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| poll_i | input | 1 | Start a poll (taken when idle) |
| trigger_i | input | 1 | Arm the pre-roll rewind |
| prepare_i | input | 1 | Clear destination offset and period accumulator (taken when idle) |
| dst_bytes_i | input | 32 | Destination buffer size in bytes |
| period_bytes_i | input | 32 | Period length in bytes |
| src_req_o | output | 1 | Source read request |
| src_addr_o | output | ADDR_W | Source word address |
| src_ready_i | input | 1 | Source read accepted, data valid |
| src_data_i | input | DATA_W | Source read data |
| dst_req_o | output | 1 | Destination write request |
| dst_addr_o | output | ADDR_W | Destination word address |
| dst_data_o | output | DATA_W | Destination write data |
| dst_ready_i | input | 1 | Destination write accepted |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Poll finished (one cycle) |
| error_o | output | 1 | Poll aborted (one cycle, with done_o) |
| period_o | output | 1 | A full period was delivered (one cycle) |
| dst_frame_o | output | 32 | Destination offset in frames |

## Verification
A wrong read offset shows up within the same poll, as a destination write that carries the data of the wrong source word. A wrong destination offset shows up as a write to the wrong address, and as a wrong `dst_frame_o` once the poll ends. A period accumulator that has drifted moves the `period_o` pulse off its expected step, and every later poll inherits the error. The scoreboard compares every destination write against a model as it happens, and checks pulse counts and the frame position after each poll. Both ports are stalled in a fixed pattern throughout.

// File: rtl/preroll_copier_pkg.sv
package preroll_copier_pkg;
  localparam int CNT_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR, S_EVAL, S_STEP, S_BLK, S_MV1, S_MV2, S_NEXT
  } ctl_state_e;

  typedef enum logic [1:0] {
    M_IDLE, M_RD, M_WR
  } mov_state_e;
endpackage

// File: rtl/preroll_copier_ptr.sv
module preroll_copier_ptr
  import preroll_copier_pkg::*;
#(
  parameter int SAMPLE_BYTES  = 131068,
  parameter int PREROLL_BYTES = 65536
) (
  input  logic [CNT_W-1:0] ptr_i,
  input  logic [CNT_W-1:0] rd_i,
  input  logic             rewind_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] rd_o,
  output logic [CNT_W-1:0] new_o
);
  localparam logic [CNT_W-1:0] SAMPLE_L = CNT_W'(SAMPLE_BYTES);
  localparam logic [CNT_W-1:0] PRE_L    = CNT_W'(PREROLL_BYTES);

  logic [CNT_W-1:0] wr, rew;

  always_comb begin
    wr      = ptr_i - CNT_W'(4);
    valid_o = wr < SAMPLE_L;
    rew     = (wr < PRE_L) ? SAMPLE_L - (PRE_L - wr) : wr - PRE_L;
    rd_o    = rewind_i ? rew : rd_i;
    new_o   = (rd_o <= wr) ? wr - rd_o : SAMPLE_L + wr - rd_o;
  end
endmodule

// File: rtl/preroll_copier_plan.sv
module preroll_copier_plan
  import preroll_copier_pkg::*;
#(
  parameter int FRAME_BYTES = 2
) (
  input  logic [CNT_W-1:0] beg_i,
  input  logic [CNT_W-1:0] end_i,
  input  logic [CNT_W-1:0] dst_off_i,
  input  logic [CNT_W-1:0] dst_bytes_i,
  output logic             err_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] first_o,
  output logic [CNT_W-1:0] second_o
);
  localparam logic [CNT_W-1:0] FRAME_L = CNT_W'(FRAME_BYTES);

  logic [CNT_W-1:0] lim, len0, len;
  logic             clip, wrap;

  always_comb begin
    err_o    = (beg_i > end_i) || (dst_bytes_i < (FRAME_L << 1));
    empty_o  = beg_i == end_i;
    lim      = dst_bytes_i - FRAME_L;
    len0     = end_i - beg_i;
    clip     = len0 > lim;
    start_o  = clip ? end_i - lim : beg_i;
    len      = clip ? lim : len0;
    wrap     = (dst_off_i + len) > dst_bytes_i;
    first_o  = wrap ? dst_bytes_i - dst_off_i : len;
    second_o = wrap ? len - first_o : '0;
  end
endmodule

// File: rtl/preroll_copier_mover.sv
module preroll_copier_mover
  import preroll_copier_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              src_req_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic              src_ready_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_req_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              dst_ready_i,
  output logic              done_o
);
  mov_state_e        st_q;
  logic [ADDR_W-1:0] sa_q, da_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      sa_q   <= '0;
      da_q   <= '0;
      left_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        M_IDLE: if (start_i) begin
          sa_q   <= src_addr_i;
          da_q   <= dst_addr_i;
          left_q <= len_i;
          st_q   <= M_RD;
        end
        M_RD: if (src_ready_i) begin
          data_q <= src_data_i;
          st_q   <= M_WR;
        end
        M_WR: if (dst_ready_i) begin
          if (left_q <= CNT_W'(1)) begin
            st_q   <= M_IDLE;
            done_q <= 1'b1;
          end else begin
            left_q <= left_q - CNT_W'(1);
            sa_q   <= sa_q + ADDR_W'(1);
            da_q   <= da_q + ADDR_W'(1);
            st_q   <= M_RD;
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign src_req_o  = st_q == M_RD;
  assign src_addr_o = sa_q;
  assign dst_req_o  = st_q == M_WR;
  assign dst_addr_o = da_q;
  assign dst_data_o = data_q;
  assign done_o     = done_q;
endmodule

// File: rtl/preroll_copier.sv
module preroll_copier
  import preroll_copier_pkg::*;
#(
  parameter int REGION_BYTES  = 131072,
  parameter int PREROLL_BYTES = 65536,
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 24,
  parameter int SRC_BASE      = 0,
  parameter int DST_BASE      = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              trigger_i,
  input  logic              prepare_i,
  input  logic [CNT_W-1:0]  dst_bytes_i,
  input  logic [CNT_W-1:0]  period_bytes_i,
  output logic              src_req_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic              src_ready_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_req_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              dst_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              period_o,
  output logic [CNT_W-1:0]  dst_frame_o
);
  localparam int FRAME_BYTES  = DATA_W / 8;
  localparam int SH           = $clog2(FRAME_BYTES);
  localparam int PTR_WORDS    = 32 / DATA_W;
  localparam int PIDX_W       = (PTR_WORDS > 1) ? $clog2(PTR_WORDS) : 1;
  localparam int SAMPLE_BYTES = REGION_BYTES - 4;
  localparam logic [CNT_W-1:0]  SAMPLE_L = CNT_W'(SAMPLE_BYTES);
  localparam logic [ADDR_W-1:0] SRC_W0   = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] SMP_W0   = ADDR_W'(SRC_BASE + PTR_WORDS);
  localparam logic [ADDR_W-1:0] DST_W0   = ADDR_W'(DST_BASE);

  function automatic logic [ADDR_W-1:0] smp_word(input logic [CNT_W-1:0] b);
    return SMP_W0 + ADDR_W'(b >> SH);
  endfunction

  ctl_state_e        st_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [CNT_W-1:0]  ptr_q, rd_q, dst_q, acc_q, rem_q, step_q, tgt_q;
  logic [CNT_W-1:0]  beg_q, end_q, cb_q, first_q, second_q;
  logic              blk_hi_q, rewind_q;
  logic              done_q, err_q, per_q;
  logic              mv_start_q;
  logic [ADDR_W-1:0] mv_src_q, mv_dst_q;
  logic [CNT_W-1:0]  mv_len_q;

  // pointer arithmetic
  logic             pv_valid;
  logic [CNT_W-1:0] pv_rd, pv_new;

  preroll_copier_ptr #(
    .SAMPLE_BYTES (SAMPLE_BYTES),
    .PREROLL_BYTES(PREROLL_BYTES)
  ) u_ptr (
    .ptr_i   (ptr_q),
    .rd_i    (rd_q),
    .rewind_i(rewind_q),
    .valid_o (pv_valid),
    .rd_o    (pv_rd),
    .new_o   (pv_new)
  );

  // block planning
  logic             pl_err, pl_empty;
  logic [CNT_W-1:0] pl_start, pl_first, pl_second;

  preroll_copier_plan #(.FRAME_BYTES(FRAME_BYTES)) u_plan (
    .beg_i      (beg_q),
    .end_i      (end_q),
    .dst_off_i  (dst_q),
    .dst_bytes_i(dst_bytes_i),
    .err_o      (pl_err),
    .empty_o    (pl_empty),
    .start_o    (pl_start),
    .first_o    (pl_first),
    .second_o   (pl_second)
  );

  // word mover
  logic              mv_src_req, mv_dst_req, mv_done;
  logic [ADDR_W-1:0] mv_src_addr;

  preroll_copier_mover #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mov (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (mv_start_q),
    .src_addr_i (mv_src_q),
    .dst_addr_i (mv_dst_q),
    .len_i      (mv_len_q),
    .src_req_o  (mv_src_req),
    .src_addr_o (mv_src_addr),
    .src_ready_i(src_ready_i),
    .src_data_i (src_data_i),
    .dst_req_o  (mv_dst_req),
    .dst_addr_o (dst_addr_o),
    .dst_data_o (dst_data_o),
    .dst_ready_i(dst_ready_i),
    .done_o     (mv_done)
  );

  // step sizing
  logic [CNT_W-1:0] room, step_c, tgt_c, acc_nx, dst_nx;
  always_comb begin
    room   = period_bytes_i - acc_q;
    step_c = (rem_q < room) ? rem_q : room;
    tgt_c  = rd_q + step_c;
    acc_nx = acc_q + step_q;
    dst_nx = dst_q + first_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      pidx_q     <= '0;
      ptr_q      <= '0;
      rd_q       <= '0;
      dst_q      <= '0;
      acc_q      <= '0;
      rem_q      <= '0;
      step_q     <= '0;
      tgt_q      <= '0;
      beg_q      <= '0;
      end_q      <= '0;
      cb_q       <= '0;
      first_q    <= '0;
      second_q   <= '0;
      blk_hi_q   <= 1'b0;
      rewind_q   <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      per_q      <= 1'b0;
      mv_start_q <= 1'b0;
      mv_src_q   <= '0;
      mv_dst_q   <= '0;
      mv_len_q   <= '0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      per_q      <= 1'b0;
      mv_start_q <= 1'b0;

      // rewind consumed only by a poll with a usable pointer
      if (st_q == S_EVAL && pv_valid) rewind_q <= trigger_i;
      else if (trigger_i)             rewind_q <= 1'b1;

      unique case (st_q)
        S_IDLE: begin
          if (poll_i) begin
            pidx_q <= '0;
            st_q   <= S_PTR;
          end else if (prepare_i) begin
            dst_q <= '0;
            acc_q <= '0;
          end
        end
        S_PTR: if (src_ready_i) begin
          ptr_q[int'(pidx_q)*DATA_W +: DATA_W] <= src_data_i;
          if (int'(pidx_q) == PTR_WORDS - 1) st_q <= S_EVAL;
          else pidx_q <= pidx_q + PIDX_W'(1);
        end
        S_EVAL: begin
          if (!pv_valid) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            rd_q  <= pv_rd;
            rem_q <= pv_new;
            st_q  <= S_STEP;
          end
        end
        S_STEP: begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (period_bytes_i == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            step_q   <= step_c;
            tgt_q    <= tgt_c;
            beg_q    <= rd_q;
            end_q    <= (tgt_c < SAMPLE_L) ? tgt_c : SAMPLE_L;
            blk_hi_q <= 1'b0;
            st_q     <= S_BLK;
          end
        end
        S_BLK: begin
          if (pl_err) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (pl_empty) begin
            st_q <= S_NEXT;
          end else begin
            cb_q       <= pl_start;
            first_q    <= pl_first;
            second_q   <= pl_second;
            mv_start_q <= 1'b1;
            mv_src_q   <= smp_word(pl_start);
            mv_dst_q   <= DST_W0 + ADDR_W'(dst_q >> SH);
            mv_len_q   <= pl_first >> SH;
            st_q       <= S_MV1;
          end
        end
        S_MV1: if (mv_done) begin
          dst_q <= (dst_nx == dst_bytes_i) ? '0 : dst_nx;
          if (second_q != '0) begin
            mv_start_q <= 1'b1;
            mv_src_q   <= smp_word(cb_q + first_q);
            mv_dst_q   <= DST_W0;
            mv_len_q   <= second_q >> SH;
            st_q       <= S_MV2;
          end else begin
            st_q <= S_NEXT;
          end
        end
        S_MV2: if (mv_done) begin
          dst_q <= second_q;
          st_q  <= S_NEXT;
        end
        S_NEXT: begin
          if (!blk_hi_q && tgt_q >= SAMPLE_L) begin
            blk_hi_q <= 1'b1;
            beg_q    <= '0;
            end_q    <= tgt_q - SAMPLE_L;
            st_q     <= S_BLK;
          end else begin
            rd_q <= (tgt_q >= SAMPLE_L) ? tgt_q - SAMPLE_L : tgt_q;
            if (acc_nx >= period_bytes_i) begin
              per_q <= 1'b1;
              acc_q <= '0;
            end else begin
              acc_q <= acc_nx;
            end
            rem_q <= rem_q - step_q;
            st_q  <= S_STEP;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign src_req_o   = (st_q == S_PTR) ? 1'b1 : mv_src_req;
  assign src_addr_o  = (st_q == S_PTR) ? SRC_W0 + ADDR_W'(pidx_q) : mv_src_addr;
  assign dst_req_o   = mv_dst_req;
  assign busy_o      = st_q != S_IDLE;
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign period_o    = per_q;
  assign dst_frame_o = dst_q >> SH;
endmodule

// File: rtl/preroll_copier_chk.sv
module preroll_copier_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              src_req_o,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic              src_ready_i,
  input logic              dst_req_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic [DATA_W-1:0] dst_data_o,
  input logic              dst_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              period_o
);
  assert_src_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_req_o && !src_ready_i |=> src_req_o && $stable(src_addr_o));

  assert_dst_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_req_o && !dst_ready_i |=> dst_req_o && $stable(dst_addr_o) && $stable(dst_data_o));

  assert_one_port_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_req_o && dst_req_o));

  assert_quiet_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !src_req_o && !dst_req_o);

  assert_err_with_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  assert_done_ends_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_period_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o);
endmodule

bind preroll_copier preroll_copier_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_req_o  (src_req_o),
  .src_addr_o (src_addr_o),
  .src_ready_i(src_ready_i),
  .dst_req_o  (dst_req_o),
  .dst_addr_o (dst_addr_o),
  .dst_data_o (dst_data_o),
  .dst_ready_i(dst_ready_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .period_o   (period_o)
);

// File: tb/preroll_copier_tb.sv
module preroll_copier_tb;
  localparam int RB = 64;
  localparam int PRE = 16;
  localparam int SMP = RB - 4;
  localparam int DBASE = 256;

  typedef struct packed {
    logic [11:0] a;
    logic [15:0] d;
  } wr_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll = 1'b0, trig = 1'b0, prep = 1'b0;
  logic [31:0] dst_bytes = 32'd40, per_bytes = 32'd8;
  logic        src_req, dst_req, src_rdy, dst_rdy;
  logic [11:0] src_addr, dst_addr;
  logic [15:0] src_data, dst_data;
  logic        busy, done, err, per;
  logic [31:0] dst_frame;
  logic [15:0] src_mem [0:31];
  logic [7:0]  cyc = '0;

  int total = 0, bad = 0;
  int seen_done = 0, seen_per = 0, seen_err = 0, seen_wr = 0;
  bit finished = 0;
  wr_t exp_q[$];

  // model state
  int m_rd = 0, m_dst = 0, m_acc = 0, m_per = 0, m_wr = 0;
  bit m_rew = 0, m_err = 0;

  always #5 clk = ~clk;

  preroll_copier #(
    .REGION_BYTES(RB), .PREROLL_BYTES(PRE), .DATA_W(16), .ADDR_W(12),
    .SRC_BASE(0), .DST_BASE(DBASE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .trigger_i(trig), .prepare_i(prep),
    .dst_bytes_i(dst_bytes), .period_bytes_i(per_bytes),
    .src_req_o(src_req), .src_addr_o(src_addr), .src_ready_i(src_rdy), .src_data_i(src_data),
    .dst_req_o(dst_req), .dst_addr_o(dst_addr), .dst_data_o(dst_data), .dst_ready_i(dst_rdy),
    .busy_o(busy), .done_o(done), .error_o(err), .period_o(per), .dst_frame_o(dst_frame)
  );

  always @(posedge clk) cyc <= cyc + 8'd1;
  assign src_rdy  = cyc[1:0] != 2'd1;
  assign dst_rdy  = (cyc[2:0] != 3'd3) && (cyc[2:0] != 3'd6);
  assign src_data = src_mem[src_addr[4:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design performs them
  always @(negedge clk) begin
    wr_t e;
    if (rst_n) begin
      if (dst_req && dst_rdy) begin
        seen_wr++;
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected dst write addr", longint'(dst_addr), -1);
        end else begin
          e = exp_q.pop_front();
          chk(dst_addr == e.a, "R8", "dst write addr", longint'(dst_addr), longint'(e.a));
          chk(dst_data == e.d, "R6 R11", "dst write data", longint'(dst_data), longint'(e.d));
        end
      end
      if (per)  seen_per++;
      if (err)  seen_err++;
      if (done) seen_done++;
    end
  end

  // reference model of one copy block; returns 1 on rejection
  function automatic bit m_block(int b, int e);
    int lim, len, first, second;
    if (b > e || int'(dst_bytes) < 4) return 1;
    if (b == e) return 0;
    lim = int'(dst_bytes) - 2;
    if (e - b > lim) b = e - lim;
    len = e - b;
    first = len;
    second = 0;
    if (m_dst + len > int'(dst_bytes)) begin
      first = int'(dst_bytes) - m_dst;
      second = len - first;
    end
    for (int i = 0; i < first / 2; i++)
      exp_q.push_back('{a: 12'(DBASE + m_dst / 2 + i), d: src_mem[2 + b / 2 + i]});
    m_dst += first;
    if (m_dst == int'(dst_bytes)) m_dst = 0;
    if (second != 0) begin
      for (int i = 0; i < second / 2; i++)
        exp_q.push_back('{a: 12'(DBASE + i), d: src_mem[2 + (b + first) / 2 + i]});
      m_dst = second;
    end
    return 0;
  endfunction

  function automatic void m_poll(int ptr);
    int wr, nb, step, tgt;
    m_err = 0;
    m_per = 0;
    m_wr  = exp_q.size();
    wr = ptr - 4;
    if (wr < 0 || wr >= SMP) begin
      m_err = 1;
      return;
    end
    if (m_rew) begin
      m_rew = 0;
      m_rd = (wr < PRE) ? SMP - (PRE - wr) : wr - PRE;
    end
    nb = (m_rd <= wr) ? wr - m_rd : SMP + wr - m_rd;
    while (nb != 0) begin
      if (per_bytes == 0) begin m_err = 1; return; end
      step = int'(per_bytes) - m_acc;
      if (nb < step) step = nb;
      tgt = m_rd + step;
      if (m_block(m_rd, (tgt < SMP) ? tgt : SMP)) begin m_err = 1; return; end
      if (tgt >= SMP) begin
        tgt -= SMP;
        if (m_block(0, tgt)) begin m_err = 1; return; end
      end
      m_rd = tgt;
      m_acc += step;
      if (m_acc >= int'(per_bytes)) begin
        m_per++;
        m_acc = 0;
      end
      nb -= step;
    end
  endfunction

  task automatic do_poll(input int ptr, input bit t, input string tag);
    int d0, p0, e0, w0, nexp;
    src_mem[0] = ptr[15:0];
    src_mem[1] = ptr[31:16];
    @(negedge clk);
    if (t) begin
      trig = 1'b1;
      m_rew = 1;
      @(negedge clk);
      trig = 1'b0;
    end
    m_poll(ptr);
    nexp = exp_q.size() - m_wr;
    d0 = seen_done; p0 = seen_per; e0 = seen_err; w0 = seen_wr;
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    while (seen_done == d0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(seen_done - d0 == 1, "R12", {tag, " done pulses"}, seen_done - d0, 1);
    chk((seen_err - e0) == int'(m_err), {tag, " R2 R9"}, "error pulses", seen_err - e0, m_err);
    chk(seen_per - p0 == m_per, {tag, " R5"}, "period pulses", seen_per - p0, m_per);
    chk(seen_wr - w0 == nexp, {tag, " R3"}, "write count", seen_wr - w0, nexp);
    chk(exp_q.size() == 0, {tag, " R3"}, "missing writes", exp_q.size(), 0);
    chk(dst_frame == 32'(m_dst / 2), {tag, " R10"}, "dst_frame", dst_frame, m_dst / 2);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) src_mem[i] = 16'(16'h1000 + i * 16'h0101 + (i % 5) * 16'h0033);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err && !per, "R1", "status low in reset", {busy, done, err, per}, 0);
    chk(!src_req && !dst_req, "R1", "no requests in reset", {src_req, dst_req}, 0);
    chk(dst_frame == 0, "R1", "dst_frame in reset", dst_frame, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && dst_frame == 0, "R1", "idle after reset", busy, 0);

    do_poll(4 + 10, 0, "R3 R5 R6 basic");
    do_poll(4 + 10, 0, "R3 no-new");
    do_poll(4 + 6, 1, "R4 R6 rewind-wrap");
    do_poll(4 + 54, 0, "R8 dst-wrap");
    do_poll(64, 1, "R2 R4 bad-ptr-high");
    do_poll(2, 0, "R2 bad-ptr-low");
    do_poll(4 + 30, 0, "R4 pending-rewind");

    dst_bytes = 32'd2;
    do_poll(4 + 40, 0, "R9 small-dst");
    dst_bytes = 32'd40;
    per_bytes = 32'd0;
    do_poll(4 + 40, 0, "R9 zero-period");
    per_bytes = 32'd8;
    do_poll(4 + 40, 0, "R9 offset-kept");

    @(negedge clk);
    prep = 1'b1;
    @(negedge clk);
    prep = 1'b0;
    m_dst = 0;
    m_acc = 0;
    @(negedge clk);
    chk(dst_frame == 0, "R10", "dst_frame after prepare", dst_frame, 0);

    dst_bytes = 32'd20;
    per_bytes = 32'd56;
    do_poll(4 + 40, 1, "R4 rewind-plain");
    do_poll(4, 0, "R7 clip");
    chk(dst_frame == 7, "R7", "dst_frame after clip", dst_frame, 7);
    do_poll(4 + 6, 0, "R8 exact-end");
    chk(dst_frame == 0, "R8", "dst_frame exact wrap", dst_frame, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule